// File: doc/BRIEF.md
# Packed Byte Absolute-Difference Accumulator

This unit executes a pixel-distance operation. Both 64-bit sources are split into eight unsigned byte lanes. For each lane it takes the absolute difference between the byte of the first source and the byte of the second. It sums the eight differences and adds that sum to a 64-bit accumulator operand. The accumulator operand is the old contents of the destination register, and the total is written back to that same register. The surrounding pipeline therefore supplies three 64-bit operands and receives one 64-bit result.

A request carries a sub-opcode, the three operands and a feature-enable bit. The unit handles only its own sub-opcode, and only when the feature is enabled. If its sub-opcode arrives with the feature disabled, the unit raises an illegal-instruction flag instead of a result. Any other sub-opcode is left to other units, so this unit stays silent. The datapath has two register stages and accepts a new request every cycle.

Top module: `pixdist_acc`

## Requirements
- R1: Lane i of each source occupies bits [63-8i : 56-8i], so lane 0 is the most significant byte. Each lane contributes the unsigned magnitude of its first-source byte minus its second-source byte, which lies in 0..255. A byte of 0x00 against 0xFF contributes 255 in either order.
- R2: The result equals the accumulator operand plus the eight lane magnitudes, taken modulo 2^64. No carry or overflow indication is produced.
- R3: When both sources are identical, the result equals the accumulator operand.
- R4: A response appears exactly two clock cycles after the request is presented. Requests on consecutive cycles each produce their own response on consecutive cycles.
- R5: The unit's sub-opcode is the 9-bit value 0x03E. A valid request with this sub-opcode and the feature enable high produces `rsp_valid` high, together with the result.
- R6: A valid request with sub-opcode 0x03E and the feature enable low produces `rsp_illegal` high and `rsp_valid` low, two cycles later.
- R7: A valid request with any other sub-opcode produces neither `rsp_valid` nor `rsp_illegal`.
- R8: A synchronous active-high reset clears all pipeline valid state. Nothing emerges from a request that was in flight when reset was applied.
- R9: `rsp_valid` and `rsp_illegal` are never high in the same cycle.
- R10: A request presented with `req_valid` low produces no response, even when its sub-opcode matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_opcode | input | 9 | Operate-group sub-opcode |
| feat_en | input | 1 | Visual-instruction feature enable |
| src_a | input | 64 | First source, eight byte lanes |
| src_b | input | 64 | Second source, eight byte lanes |
| acc_in | input | 64 | Old destination contents (accumulator) |
| rsp_valid | output | 1 | Result valid |
| rsp_illegal | output | 1 | Illegal-instruction indication |
| rsp_result | output | 64 | Accumulated sum |

## Verification
The bench sends all-0x00 against all-0xFF in both orders. A lane that subtracts without taking the magnitude, or that works at only 8 bits, gives 1 instead of 255 for 0x00 against 0xFF and misses the expected 2040. With an accumulator of all ones, a correct sum wraps to 0x7F7. Identical operands check that the accumulator passes through unchanged. Feature-disabled requests, foreign sub-opcodes, idle-strobe requests and a reset with requests in flight each catch a decode or valid path that lets through a spurious result or flag, or drops a real one. A dense random stream checks that the latency is two cycles and the throughput one request per cycle.

// File: rtl/pixdist_pkg.sv
package pixdist_pkg;

   typedef enum logic [1:0] {
      OPC_NONE = 2'd0,
      OPC_EXEC = 2'd1,
      OPC_TRAP = 2'd2
   } op_class_e;

   function automatic int unsigned sum_width(input int unsigned elem_w, input int unsigned count);
      return elem_w + $clog2(count);
   endfunction

endpackage

// File: rtl/pixdist_decode.sv
module pixdist_decode
   import pixdist_pkg::*;
#(
   parameter int unsigned OP_W = 9,
   parameter logic [OP_W-1:0] MATCH_OP = 'h03E
) (
   input  logic            req_valid_i,
   input  logic [OP_W-1:0] opcode_i,
   input  logic            feat_en_i,
   output op_class_e       cls_o
);

   always_comb begin
      cls_o = OPC_NONE;
      if (req_valid_i && (opcode_i == MATCH_OP)) begin
         cls_o = feat_en_i ? OPC_EXEC : OPC_TRAP;
      end
   end

endmodule

// File: rtl/pixdist_lane_mag.sv
module pixdist_lane_mag #(
   parameter int unsigned LANE_W = 8,
   parameter bit SIGNED_DIFF = 1'b1
) (
   input  logic [LANE_W-1:0] a_i,
   input  logic [LANE_W-1:0] b_i,
   output logic [LANE_W-1:0] mag_o
);

   if (SIGNED_DIFF) begin : g_signed
      logic signed [LANE_W:0] diff;
      logic signed [LANE_W:0] absd;
      always_comb begin
         diff = $signed({1'b0, a_i}) - $signed({1'b0, b_i});
         absd = diff[LANE_W] ? -diff : diff;
         mag_o = absd[LANE_W-1:0];
      end
   end else begin : g_compare
      always_comb begin
         mag_o = (a_i >= b_i) ? (a_i - b_i) : (b_i - a_i);
      end
   end

   // zero magnitude exactly when the two lane bytes agree
   always_comb begin
      assert_zero_iff_equal_R3: assert ((mag_o == '0) == (a_i == b_i));
   end

endmodule

// File: rtl/pixdist_part_sum.sv
module pixdist_part_sum
   import pixdist_pkg::*;
#(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned COUNT  = 4,
   localparam int unsigned SUM_W = sum_width(LANE_W, COUNT)
) (
   input  logic [COUNT-1:0][LANE_W-1:0] mag_i,
   output logic [SUM_W-1:0]             sum_o
);

   always_comb begin
      sum_o = '0;
      for (int k = 0; k < int'(COUNT); k++) begin
         sum_o = sum_o + SUM_W'(mag_i[k]);
      end
   end

endmodule

// File: rtl/pixdist_acc.sv
module pixdist_acc
   import pixdist_pkg::*;
#(
   parameter int unsigned LANES  = 8,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned ACC_W  = 64,
   parameter int unsigned PARTS  = 2,
   parameter int unsigned OP_W   = 9,
   parameter logic [OP_W-1:0] MATCH_OP = 'h03E,
   parameter bit SIGNED_DIFF = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    req_valid,
   input  logic [OP_W-1:0]         req_opcode,
   input  logic                    feat_en,
   input  logic [LANES*LANE_W-1:0] src_a,
   input  logic [LANES*LANE_W-1:0] src_b,
   input  logic [ACC_W-1:0]        acc_in,
   output logic                    rsp_valid,
   output logic                    rsp_illegal,
   output logic [ACC_W-1:0]        rsp_result
);

   localparam int unsigned DATA_W = LANES * LANE_W;
   localparam int unsigned PER_PART = LANES / PARTS;
   localparam int unsigned PART_W = sum_width(LANE_W, PER_PART);
   localparam int unsigned TOT_W  = sum_width(LANE_W, LANES);

   if (PARTS == 0 || (LANES % PARTS) != 0) begin : g_bad_parts
      $error("LANES must be a nonzero multiple of PARTS");
   end
   if (ACC_W < TOT_W) begin : g_bad_acc
      $error("ACC_W too narrow for the lane sum");
   end
   if (LANE_W < 2) begin : g_bad_lane
      $error("LANE_W must be at least 2");
   end

   op_class_e cls;

   pixdist_decode #(.OP_W(OP_W), .MATCH_OP(MATCH_OP)) u_decode (
      .req_valid_i (req_valid),
      .opcode_i    (req_opcode),
      .feat_en_i   (feat_en),
      .cls_o       (cls)
   );

   // stage 1: lane magnitudes and partial sums
   logic [LANES-1:0][LANE_W-1:0] mags;
   logic [PARTS-1:0][PART_W-1:0] parts;

   for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
      pixdist_lane_mag #(.LANE_W(LANE_W), .SIGNED_DIFF(SIGNED_DIFF)) u_mag (
         .a_i   (src_a[DATA_W-1-i*LANE_W -: LANE_W]),
         .b_i   (src_b[DATA_W-1-i*LANE_W -: LANE_W]),
         .mag_o (mags[i])
      );
   end

   for (genvar p = 0; p < int'(PARTS); p++) begin : g_part
      pixdist_part_sum #(.LANE_W(LANE_W), .COUNT(PER_PART)) u_psum (
         .mag_i (mags[p*PER_PART +: PER_PART]),
         .sum_o (parts[p])
      );
   end

   logic                         s1_vld;
   logic                         s1_ill;
   logic [ACC_W-1:0]             s1_acc;
   logic [PARTS-1:0][PART_W-1:0] s1_parts;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld <= 1'b0;
         s1_ill <= 1'b0;
      end else begin
         s1_vld <= (cls == OPC_EXEC);
         s1_ill <= (cls == OPC_TRAP);
      end
   end

   always_ff @(posedge clk) begin
      if (cls == OPC_EXEC) begin
         s1_acc   <= acc_in;
         s1_parts <= parts;
      end
   end

   // stage 2: finish the tree and accumulate
   logic [TOT_W-1:0] total;

   always_comb begin
      total = '0;
      for (int q = 0; q < int'(PARTS); q++) begin
         total = total + TOT_W'(s1_parts[q]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid   <= 1'b0;
         rsp_illegal <= 1'b0;
      end else begin
         rsp_valid   <= s1_vld;
         rsp_illegal <= s1_ill;
      end
   end

   always_ff @(posedge clk) begin
      if (s1_vld) begin
         rsp_result <= s1_acc + ACC_W'(total);
      end
   end

   // legal request yields a result two cycles on
   assert_exec_latency_R4: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_opcode == MATCH_OP && feat_en) |=> ##1 (rsp_valid && !rsp_illegal));

   // disabled feature yields only the illegal flag
   assert_trap_when_disabled_R6: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_opcode == MATCH_OP && !feat_en) |=> ##1 (rsp_illegal && !rsp_valid));

   // foreign sub-opcode or idle strobe yields nothing
   assert_silent_other_R7: assert property (@(posedge clk) disable iff (rst)
      (!req_valid || req_opcode != MATCH_OP) |=> ##1 (!rsp_valid && !rsp_illegal));

   // identical sources leave the accumulator unchanged
   assert_identity_passthru_R3: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_opcode == MATCH_OP && feat_en && src_a == src_b)
      |=> ##1 (rsp_result == $past(acc_in, 2)));

   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
      !(rsp_valid && rsp_illegal));

   assert_reset_clears_R8: assert property (@(posedge clk)
      $past(rst) |-> (!rsp_valid && !rsp_illegal));

endmodule

// File: tb/pixdist_acc_tb_top.sv
module pixdist_acc_tb_top;

   localparam logic [8:0] OPC = 9'h03E;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rv = 1'b0;
   logic [8:0]  op = '0;
   logic        fe = 1'b0;
   logic [63:0] a = '0, b = '0, acc = '0;
   logic        rsp_valid, rsp_illegal;
   logic [63:0] rsp_result;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   pixdist_acc dut_i (
      .clk (clk), .rst (rst), .req_valid (rv), .req_opcode (op), .feat_en (fe),
      .src_a (a), .src_b (b), .acc_in (acc),
      .rsp_valid (rsp_valid), .rsp_illegal (rsp_illegal), .rsp_result (rsp_result)
   );

   function automatic logic [63:0] model(input logic [63:0] x, input logic [63:0] y,
                                         input logic [63:0] s);
      logic [63:0] t = s;
      for (int i = 0; i < 8; i++) begin
         logic [7:0] p = x[63-8*i -: 8];
         logic [7:0] q = y[63-8*i -: 8];
         t = t + 64'((p > q) ? (p - q) : (q - p));
      end
      return t;
   endfunction

   // expected-response pipeline, two deep
   logic d1_live = 0, d1_v = 0, d1_i = 0, d2_live = 0, d2_v = 0, d2_i = 0;
   logic [63:0] d1_r = '0, d2_r = '0;
   string d1_tag = "", d2_tag = "";

   task automatic check(input logic ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic rv_, input logic [8:0] op_, input logic fe_,
                      input logic [63:0] a_, input logic [63:0] b_, input logic [63:0] s_,
                      input string tag);
      @(negedge clk);
      if (d2_live) begin
         check(rsp_valid == d2_v && rsp_illegal == d2_i, {d2_tag, " flags"},
               {62'd0, rsp_valid, rsp_illegal}, {62'd0, d2_v, d2_i});
         if (d2_v) check(rsp_result == d2_r, {d2_tag, " result"}, rsp_result, d2_r);
      end
      d2_live = d1_live; d2_v = d1_v; d2_i = d1_i; d2_r = d1_r; d2_tag = d1_tag;
      d1_live = 1'b1;
      d1_v = rv_ && op_ == OPC && fe_;
      d1_i = rv_ && op_ == OPC && !fe_;
      d1_r = model(a_, b_, s_);
      d1_tag = tag;
      rv = rv_; op = op_; fe = fe_; a = a_; b = b_; acc = s_;
   endtask

   task automatic idle(input string tag);
      cyc(1'b0, 9'h000, 1'b1, 64'd0, 64'd0, 64'd0, tag);
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20111017));
      repeat (3) @(negedge clk);
      check(!rsp_valid && !rsp_illegal, "R8 reset state", {63'd0, rsp_valid}, 64'd0);
      rst = 1'b0;

      // R1: all lanes 0x00 vs 0xFF, both orders, gives 2040
      cyc(1, OPC, 1, 64'h0, {8{8'hFF}}, 64'd0, "R1 zero-vs-ff");
      cyc(1, OPC, 1, {8{8'hFF}}, 64'h0, 64'd0, "R1 ff-vs-zero");
      cyc(1, OPC, 1, 64'h00FF_00FF_FF00_FF00, 64'hFF00_FF00_00FF_00FF, 64'd5, "R1 mixed");
      // R2: wraparound near 2^64-1, expected 0x7F7
      cyc(1, OPC, 1, {8{8'hFF}}, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 wrap");
      cyc(1, OPC, 1, 64'h0100_0000_0000_0000, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 wrap-to-zero");
      // R3: identical operands
      cyc(1, OPC, 1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0,
          64'hDEAD_BEEF_0BAD_F00D, "R3 identical");
      // R6: feature disabled
      cyc(1, OPC, 0, {8{8'hFF}}, 64'h0, 64'd1, "R6 disabled");
      // R7: foreign sub-opcodes
      cyc(1, 9'h03D, 1, {8{8'hFF}}, 64'h0, 64'd1, "R7 other-op");
      cyc(1, 9'h13E, 0, {8{8'hFF}}, 64'h0, 64'd1, "R7 other-op-dis");
      // R10: strobe low
      cyc(0, OPC, 1, {8{8'hFF}}, 64'h0, 64'd1, "R10 no-strobe");
      cyc(0, OPC, 0, {8{8'hFF}}, 64'h0, 64'd1, "R10 no-strobe-dis");
      // R9: alternate illegal and legal back to back
      cyc(1, OPC, 0, 64'd3, 64'd9, 64'd0, "R9 alt-ill");
      cyc(1, OPC, 1, 64'd3, 64'd9, 64'd0, "R9 alt-ok");
      idle("R4 drain"); idle("R4 drain");

      // R8: reset with requests in flight
      cyc(1, OPC, 1, 64'd7, 64'd1, 64'd0, "R8 pre");
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(!rsp_valid && !rsp_illegal, "R8 during reset", {63'd0, rsp_valid}, 64'd0);
      rst = 1'b0;
      d1_live = 1; d1_v = 0; d1_i = 0; d1_tag = "R8 post";
      d2_live = 1; d2_v = 0; d2_i = 0; d2_tag = "R8 post";
      rv = 0;
      idle("R8 post"); idle("R8 post");

      // R4/R5: dense random stream with some foreign opcodes and disables
      for (int k = 0; k < 400; k++) begin
         logic [8:0] o;
         logic [31:0] r = $urandom;
         o = (r[2:0] == 3'd0) ? 9'($urandom) : OPC;
         cyc(r[3:0] != 4'd15, o, r[7:4] != 4'd0,
             {$urandom, $urandom}, {$urandom, $urandom},
             r[8] ? 64'hFFFF_FFFF_FFFF_FF00 | 64'($urandom % 256) : {$urandom, $urandom},
             "R4 R5 random");
      end
      idle("R4 drain"); idle("R4 drain"); idle("R4 drain");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule